// File: doc/BRIEF.md
# Program Exception Reporting Unit

This unit takes one program exception request at a time and turns it into the state change a processor makes when it enters its program exception handler. A request carries a 16-bit interruption code, the length of the faulting instruction in bytes, a request kind (plain, data exception or vector exception), an 8-bit exception code for the data and vector kinds, and the current state word (mask and instruction address). The debug-event monitor may also have an event pending, which it presents as an event identifier and an event address.

The unit does four things. It decides from the interruption code whether the saved instruction address steps past the faulting instruction. It folds any pending debug event into the code and clears that event. For data and vector requests it places the exception code into the floating-point control word. It then writes the old-state record as a fixed series of words on a store port and loads the new state word. Requests use a valid/ready handshake, and `req_ready` is high only while the unit is idle. The store port is also valid/ready: a word is held stable until `st_ready` takes it, so memory can apply back-pressure for any number of cycles.

Top module: `pex_report`

## Requirements
- R1: `req_ready` is 1 only when the unit is idle. A request is taken in the cycle where `req_valid` and `req_ready` are both 1. After reset `req_ready` is 1 and every other output is 0.
- R2: An instruction length other than 2, 4 or 6 gives a one-cycle `err` pulse in the cycle after the request is taken. In that case nothing is stored, `done`, `fpc_we` and `per_clear` stay 0, and the unit is ready again.
- R3: The saved address (store word sel 3) is `cur_addr + ilen` modulo 2^AW when the effective code is one of 0x0001–0x000F, 0x0012, 0x0013, 0x0015, 0x001D, 0x001F, 0x0030 or 0x0040. For every other code it equals `cur_addr`.
- R4: Effective code 0x0080 (debug event) advances the address like R3 unless a debug event is pending whose identifier has bit 8 set. In that case the address is not advanced.
- R5: When `per_pending` is 1 at request time, the stored code is the effective code ORed with 0x0080. Two extra words are stored (event address, sel 5; identifier, sel 6), and `per_clear` pulses in the cycle after the request is taken.
- R6: Kind 1 (data) uses effective code 0x0007 and ignores `req_code`. `fpc_we` pulses in the cycle after the request is taken only if `afp_en` was 1. `fpc_out` is `fpc_in` with bits 15:8 replaced by `req_xcode[7:0]`.
- R7: Kind 2 (vector) uses effective code 0x001B and ignores `req_code`. It always pulses `fpc_we`, with the same deposit as R6, whatever `afp_en` is.
- R8: For kinds 1 and 2, nonzero `req_xcode[15:8]` is an error handled as in R2. Kind 3 is always an error. For kind 0, `req_xcode` has no effect.
- R9: Store words go out in sel order 0 (length), 1 (code), 2 (old mask), 3 (saved address), 4 (breaking-event address), then 5 and 6 only under R5. Each word is held with `st_valid` high and unchanged until `st_ready` is 1.
- R10: `done` is 1 for exactly one cycle, the cycle after the last store handshake. From that cycle on, `psw_mask`/`psw_addr` hold the `new_mask`/`new_addr` values captured when the request was taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Unit idle, request can be taken |
| req_kind | input | 2 | 0 plain, 1 data, 2 vector, 3 reserved |
| req_code | input | 16 | Interruption code for plain requests |
| req_xcode | input | 16 | Exception code for data/vector (must fit 8 bits) |
| req_ilen | input | 3 | Instruction length in bytes |
| per_pending | input | 1 | Debug event pending |
| per_id | input | 16 | Debug event identifier, bit 8 = nullifying |
| per_addr | input | AW | Debug event address |
| cur_mask | input | AW | Current state mask |
| cur_addr | input | AW | Current instruction address |
| bea_addr | input | AW | Last breaking-event address |
| new_mask | input | AW | Handler state mask |
| new_addr | input | AW | Handler entry address |
| afp_en | input | 1 | Extra floating-point enable |
| fpc_in | input | 32 | Current floating-point control word |
| fpc_we | output | 1 | Write strobe for the control word |
| fpc_out | output | 32 | Updated control word |
| per_clear | output | 1 | Clear the pending debug event |
| err | output | 1 | Malformed request pulse |
| st_valid | output | 1 | Store word valid |
| st_ready | input | 1 | Store word accepted |
| st_sel | output | 3 | Record field of the word |
| st_data | output | AW | Store word, zero-extended |
| done | output | 1 | New state loaded |
| psw_mask | output | AW | Loaded state mask |
| psw_addr | output | AW | Loaded state address |

## Verification
The assertions assume that `st_ready` reflects a memory that eventually accepts. They also assume that the request sideband (code, length, event fields and state words) is relevant only in the accept cycle, since the unit captures it there. The stimulus changes inputs only at the falling edge. It raises `req_valid` only when the unit is idle and drops it right after acceptance. It also gates `st_ready` with a repeating pattern, so words are stalled for one or more cycles and the hold rule is exercised on most records. The sweep covers every length code from 0 to 7 against a full range of interruption codes. It also covers both event flags and both enable settings, plus exception codes that cross the 8-bit limit.

// File: rtl/pex_pkg.sv
package pex_pkg;
  localparam logic [1:0] KIND_PLAIN = 2'd0;
  localparam logic [1:0] KIND_DATA  = 2'd1;
  localparam logic [1:0] KIND_VEC   = 2'd2;
  localparam logic [1:0] KIND_RSVD  = 2'd3;

  localparam logic [15:0] CODE_DATA = 16'h0007;
  localparam logic [15:0] CODE_VEC  = 16'h001B;
  localparam logic [15:0] CODE_DBG  = 16'h0080;
  localparam int          DBG_NULL_BIT = 8;

  localparam logic [2:0] SEL_ILEN  = 3'd0;
  localparam logic [2:0] SEL_CODE  = 3'd1;
  localparam logic [2:0] SEL_OMASK = 3'd2;
  localparam logic [2:0] SEL_OADDR = 3'd3;
  localparam logic [2:0] SEL_BEA   = 3'd4;
  localparam logic [2:0] SEL_PADDR = 3'd5;
  localparam logic [2:0] SEL_PID   = 3'd6;

  typedef enum logic [1:0] {ST_IDLE, ST_STORE, ST_DONE} pex_state_e;

  // codes whose instruction completes: saved address steps past it
  function automatic logic completes(input logic [15:0] c);
    logic r;
    r = (c >= 16'h0001 && c <= 16'h000F);
    if (c == 16'h0012 || c == 16'h0013 || c == 16'h0015 || c == 16'h001D ||
        c == 16'h001F || c == 16'h0030 || c == 16'h0040)
      r = 1'b1;
    return r;
  endfunction

  function automatic logic len_ok(input logic [2:0] l);
    return (l == 3'd2) || (l == 3'd4) || (l == 3'd6);
  endfunction
endpackage

// File: rtl/pex_advance.sv
module pex_advance #(
  parameter int AW = 64
) (
  input  logic [15:0]   base_code,
  input  logic [2:0]    ilen,
  input  logic          dbg_pend,
  input  logic          dbg_null,
  input  logic [AW-1:0] cur_addr,
  output logic          adv,
  output logic [AW-1:0] saved_addr,
  output logic [15:0]   final_code
);
  import pex_pkg::*;
  localparam int PADW = AW - 3;

  always_comb begin
    adv = completes(base_code) ||
          (base_code == CODE_DBG && !(dbg_pend && dbg_null));
    saved_addr = adv ? cur_addr + {{PADW{1'b0}}, ilen} : cur_addr;
    final_code = base_code | (dbg_pend ? CODE_DBG : 16'h0000);
  end

  always_comb begin
    if (!adv) assert_noadv_keeps_addr_R3: assert (saved_addr == cur_addr);
  end
endmodule

// File: rtl/pex_fpc_merge.sv
module pex_fpc_merge #(
  parameter int FW = 32,
  parameter int LO = 8
) (
  input  logic [1:0]    kind,
  input  logic          afp_en,
  input  logic [7:0]    xcode,
  input  logic [FW-1:0] fpc_in,
  output logic          we,
  output logic [FW-1:0] fpc_new
);
  import pex_pkg::*;
  localparam int HI = LO + 8;

  always_comb begin
    we = (kind == KIND_VEC) || (kind == KIND_DATA && afp_en);
    fpc_new = fpc_in;
    fpc_new[HI-1:LO] = xcode;
  end

  always_comb begin
    assert_fpc_untouched_bits_R6: assert (fpc_new[FW-1:HI] == fpc_in[FW-1:HI] &&
                                          fpc_new[LO-1:0] == fpc_in[LO-1:0]);
  end
endmodule

// File: rtl/pex_rec_seq.sv
module pex_rec_seq #(
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          with_dbg,
  input  logic [2:0]    f_ilen,
  input  logic [15:0]   f_code,
  input  logic [DW-1:0] f_omask,
  input  logic [DW-1:0] f_oaddr,
  input  logic [DW-1:0] f_bea,
  input  logic [DW-1:0] f_paddr,
  input  logic [15:0]   f_pid,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [2:0]    st_sel,
  output logic [DW-1:0] st_data,
  output logic          fin
);
  import pex_pkg::*;
  localparam int P3  = DW - 3;
  localparam int P16 = DW - 16;

  logic       busy;
  logic [2:0] idx;
  logic [2:0] last;

  assign last     = with_dbg ? SEL_PID : SEL_BEA;
  assign st_valid = busy;
  assign st_sel   = idx;
  assign fin      = busy && st_ready && (idx == last);

  always_comb begin
    case (idx)
      SEL_ILEN:  st_data = {{P3{1'b0}}, f_ilen};
      SEL_CODE:  st_data = {{P16{1'b0}}, f_code};
      SEL_OMASK: st_data = f_omask;
      SEL_OADDR: st_data = f_oaddr;
      SEL_BEA:   st_data = f_bea;
      SEL_PADDR: st_data = f_paddr;
      SEL_PID:   st_data = {{P16{1'b0}}, f_pid};
      default:   st_data = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      idx  <= '0;
    end else if (busy && st_ready) begin
      if (idx == last) busy <= 1'b0;
      else             idx  <= idx + 3'd1;
    end
  end

  assert_store_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && !st_ready) |=> (st_valid && $stable(st_sel) && $stable(st_data)));
  assert_sel_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> (st_sel <= SEL_PID));
endmodule

// File: rtl/pex_report.sv
module pex_report #(
  parameter int AW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [1:0]    req_kind,
  input  logic [15:0]   req_code,
  input  logic [15:0]   req_xcode,
  input  logic [2:0]    req_ilen,
  input  logic          per_pending,
  input  logic [15:0]   per_id,
  input  logic [AW-1:0] per_addr,
  input  logic [AW-1:0] cur_mask,
  input  logic [AW-1:0] cur_addr,
  input  logic [AW-1:0] bea_addr,
  input  logic [AW-1:0] new_mask,
  input  logic [AW-1:0] new_addr,
  input  logic          afp_en,
  input  logic [31:0]   fpc_in,
  output logic          fpc_we,
  output logic [31:0]   fpc_out,
  output logic          per_clear,
  output logic          err,
  output logic          st_valid,
  input  logic          st_ready,
  output logic [2:0]    st_sel,
  output logic [AW-1:0] st_data,
  output logic          done,
  output logic [AW-1:0] psw_mask,
  output logic [AW-1:0] psw_addr
);
  import pex_pkg::*;

  pex_state_e state;
  logic       take, bad, fin;
  logic [15:0] base_code, fin_code;
  logic        adv;
  logic [AW-1:0] saved_addr;
  logic        fpc_we_c;
  logic [31:0] fpc_new;

  logic [2:0]    l_ilen;
  logic [15:0]   l_code, l_pid;
  logic          l_dbg;
  logic [AW-1:0] l_omask, l_oaddr, l_bea, l_paddr, l_nmask, l_naddr;

  assign req_ready = (state == ST_IDLE);
  assign take      = req_valid && req_ready;
  assign done      = (state == ST_DONE);
  assign bad       = !len_ok(req_ilen) || (req_kind == KIND_RSVD) ||
                     (req_kind != KIND_PLAIN && req_xcode[15:8] != 8'h00);

  always_comb begin
    case (req_kind)
      KIND_DATA: base_code = CODE_DATA;
      KIND_VEC:  base_code = CODE_VEC;
      default:   base_code = req_code;
    endcase
  end

  pex_advance #(.AW(AW)) u_adv (
    .base_code (base_code),
    .ilen      (req_ilen),
    .dbg_pend  (per_pending),
    .dbg_null  (per_id[DBG_NULL_BIT]),
    .cur_addr  (cur_addr),
    .adv       (adv),
    .saved_addr(saved_addr),
    .final_code(fin_code)
  );

  pex_fpc_merge #(.FW(32), .LO(8)) u_fpc (
    .kind   (req_kind),
    .afp_en (afp_en),
    .xcode  (req_xcode[7:0]),
    .fpc_in (fpc_in),
    .we     (fpc_we_c),
    .fpc_new(fpc_new)
  );

  pex_rec_seq #(.DW(AW)) u_seq (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (take && !bad),
    .with_dbg(l_dbg),
    .f_ilen  (l_ilen),
    .f_code  (l_code),
    .f_omask (l_omask),
    .f_oaddr (l_oaddr),
    .f_bea   (l_bea),
    .f_paddr (l_paddr),
    .f_pid   (l_pid),
    .st_valid(st_valid),
    .st_ready(st_ready),
    .st_sel  (st_sel),
    .st_data (st_data),
    .fin     (fin)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      err       <= 1'b0;
      fpc_we    <= 1'b0;
      fpc_out   <= '0;
      per_clear <= 1'b0;
      psw_mask  <= '0;
      psw_addr  <= '0;
      l_ilen    <= '0;
      l_code    <= '0;
      l_pid     <= '0;
      l_dbg     <= 1'b0;
      l_omask   <= '0;
      l_oaddr   <= '0;
      l_bea     <= '0;
      l_paddr   <= '0;
      l_nmask   <= '0;
      l_naddr   <= '0;
    end else begin
      err       <= 1'b0;
      fpc_we    <= 1'b0;
      per_clear <= 1'b0;
      case (state)
        ST_IDLE: if (take) begin
          if (bad) begin
            err <= 1'b1;
          end else begin
            state     <= ST_STORE;
            fpc_we    <= fpc_we_c;
            fpc_out   <= fpc_new;
            per_clear <= per_pending;
            l_ilen    <= req_ilen;
            l_code    <= fin_code;
            l_pid     <= per_id;
            l_dbg     <= per_pending;
            l_omask   <= cur_mask;
            l_oaddr   <= saved_addr;
            l_bea     <= bea_addr;
            l_paddr   <= per_addr;
            l_nmask   <= new_mask;
            l_naddr   <= new_addr;
          end
        end
        ST_STORE: if (fin) begin
          state    <= ST_DONE;
          psw_mask <= l_nmask;
          psw_addr <= l_naddr;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assert_dbg_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !bad && per_pending) |=> per_clear);
  assert_bad_no_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && bad) |=> (err && !st_valid && req_ready));
  assert_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({err, done, st_valid}));
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_ready_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> !req_ready);
endmodule

// File: tb/sim_pex_report.sv
module sim_pex_report;
  localparam int CLK_NS = 10;
  localparam int AW = 64;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_ready;
  logic [1:0] req_kind = 0;
  logic [15:0] req_code = 0, req_xcode = 0, per_id = 0;
  logic [2:0] req_ilen = 0;
  logic per_pending = 0, afp_en = 0, st_ready = 0;
  logic [AW-1:0] per_addr = 0, cur_mask = 0, cur_addr = 0, bea_addr = 0, new_mask = 0, new_addr = 0;
  logic [31:0] fpc_in = 0, fpc_out;
  logic fpc_we, per_clear, err, st_valid, done;
  logic [2:0] st_sel;
  logic [AW-1:0] st_data, psw_mask, psw_addr;

  int checks = 0, fails = 0, bp = 0;

  always #(CLK_NS/2) clk = ~clk;

  pex_report #(.AW(AW)) u0 (.*);

  task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  function automatic logic nonnull(input logic [15:0] c);
    return (c >= 1 && c <= 15) || c == 16'h12 || c == 16'h13 || c == 16'h15 ||
           c == 16'h1D || c == 16'h1F || c == 16'h30 || c == 16'h40;
  endfunction

  task automatic run(input logic [1:0] kind, input logic [15:0] code, input logic [15:0] xc,
                     input logic [2:0] il, input logic pp, input logic [15:0] pid, input logic afp);
    logic e_err, adv, e_we;
    logic [15:0] base;
    logic [63:0] ew [7];
    int nw, n;
    bit seen_done;
    e_err = !(il == 2 || il == 4 || il == 6) || kind == 3 || (kind != 0 && xc[15:8] != 0);
    base = (kind == 1) ? 16'h0007 : (kind == 2) ? 16'h001B : code;
    adv = nonnull(base) || (base == 16'h0080 && !(pp && pid[8]));
    e_we = (kind == 2) || (kind == 1 && afp);
    req_kind = kind; req_code = code; req_xcode = xc; req_ilen = il;
    per_pending = pp; per_id = pid; afp_en = afp;
    cur_addr = 64'hFFFF_FFFF_FFFF_FFF0 | {60'h0, code[3:0]};
    cur_mask = {48'h0704_0000_0000, code};
    bea_addr = 64'h0000_1234_0000_0000 | {48'h0, code};
    per_addr = 64'h00AB_0000_0000_0000 | {48'h0, pid};
    new_mask = 64'h0180_0000_0000_0000 ^ {48'h0, code};
    new_addr = 64'h0000_0000_0002_0000 + {48'h0, code};
    fpc_in = 32'hA5C3_5A3C ^ {16'h0, code};
    ew[0] = {61'h0, il};
    ew[1] = {48'h0, base | (pp ? 16'h0080 : 16'h0)};
    ew[2] = cur_mask;
    ew[3] = adv ? cur_addr + {61'h0, il} : cur_addr;
    ew[4] = bea_addr;
    ew[5] = per_addr;
    ew[6] = {48'h0, pid};
    nw = pp ? 7 : 5;
    chk("R1 ready idle", req_ready, 1);
    req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    chk("R2/R8 err pulse", err, e_err);
    chk("R6/R7 fpc_we", fpc_we, e_err ? 0 : e_we);
    if (!e_err && e_we)
      chk("R6/R7 fpc deposit", fpc_out, {fpc_in[31:16], xc[7:0], fpc_in[7:0]});
    chk("R5 per_clear", per_clear, e_err ? 0 : pp);
    chk("R1 ready after take", req_ready, e_err);
    n = 0; seen_done = 0;
    for (int c = 0; c < 40 && !seen_done; c++) begin
      bp++;
      st_ready = (bp % 3) != 1;
      if (st_valid) begin
        if (n < nw) begin
          chk("R9 sel", st_sel, n[2:0]);
          chk(n == 3 ? "R3/R4 saved addr" : (n == 1 ? "R5 code" : "R9 data"), st_data, ew[n]);
        end else chk("R9 extra word", 1, 0);
        if (st_ready) n++;
      end
      if (done) begin
        seen_done = 1;
        chk("R10 word count", n, nw);
        chk("R10 psw mask", psw_mask, new_mask);
        chk("R10 psw addr", psw_addr, new_addr);
      end
      if (e_err && c == 3) break;
      @(negedge clk);
    end
    st_ready = 0;
    chk("R10/R2 done seen", seen_done, !e_err);
    if (seen_done) begin
      @(negedge clk);
      chk("R10 done single", done, 0);
    end
  endtask

  initial begin
    #(CLK_NS * 150000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 reset ready", req_ready, 1);
    chk("R1 reset st_valid", st_valid, 0);
    chk("R1 reset done", done, 0);
    chk("R1 reset err", err, 0);
    chk("R1 reset fpc_we", fpc_we, 0);
    chk("R1 reset per_clear", per_clear, 0);
    chk("R1 reset psw", psw_addr | psw_mask, 0);
    // R3 and R2: plain codes against all length codes; xcode high bits ignored (R8)
    for (int c = 0; c <= 16'h48; c++)
      for (int l = 0; l < 8; l++)
        run(2'd0, c[15:0], 16'hFF00, l[2:0], 0, 0, 0);
    for (int l = 0; l < 8; l++) run(2'd0, 16'h0080, 0, l[2:0], 0, 0, 0);
    // R4, R5: debug event pending, with and without nullify
    for (int k = 0; k < 6; k++)
      for (int nf = 0; nf < 2; nf++)
        for (int l = 2; l <= 6; l += 2) begin
          logic [15:0] cc;
          cc = (k == 0) ? 16'h01 : (k == 1) ? 16'h80 : (k == 2) ? 16'h11 :
               (k == 3) ? 16'h40 : (k == 4) ? 16'h1B : 16'h30;
          run(2'd0, cc, 0, l[2:0], 1, nf ? 16'h0140 : 16'h0040, 0);
        end
    // R6, R7, R8: data and vector paths
    for (int kd = 1; kd <= 2; kd++)
      for (int a = 0; a < 2; a++)
        for (int x = 0; x < 16'h220; x += 16'h1F) begin
          run(kd[1:0], 16'h0003, x[15:0], 3'd4, 0, 0, a[0]);
          run(kd[1:0], 16'h0055, x[15:0], 3'd6, 1, 16'h0100, a[0]);
        end
    run(2'd1, 0, 16'h0100, 3'd2, 0, 0, 1);
    run(2'd2, 0, 16'h8000, 3'd2, 0, 0, 1);
    run(2'd3, 16'h0001, 0, 3'd2, 0, 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule